// File: doc/BRIEF.md
# Banked Clock Fanout Controller

This block takes two reference clocks, picks one of them with a select input and copies the chosen clock onto sixteen outputs. The outputs are grouped in four banks of four. Each bank has two controls of its own. A rate control passes the clock either unchanged or at half frequency. A bank enable either passes the clock or holds the bank low. All four outputs of a bank always carry the same value.

Both bank controls go through a per-bank latch. The latch is open only while the bank's possible sources are both low: the selected clock, and the half-rate register. As a result, turning a bank on or off, or changing its rate, never shortens a high pulse. An active-low master control clears the half-rate state and drops the tri-state enable of every bank. The high-impedance state is represented as one output-enable signal per bank.

Top module: `clk_fanout_bank`

## Requirements
- R1: With `ref_sel` low the selected clock is `clk_a`. With `ref_sel` high it is `clk_b`. A full-rate bank output has the same period as the selected clock.
- R2: The four outputs of bank b, `q[4b+3:4b]`, are always equal to each other. With `bank_full[b]`=1 the bank runs at the selected clock period.
- R3: With `bank_full[b]`=0 the bank runs at twice the selected clock period.
- R4: With `bank_en[b]`=0 the outputs of bank b stay at 0. `q_oe[b]` stays 1 while `mr_n` is high.
- R5: While `mr_n` is 0, every `q_oe` bit is 0 (outputs high impedance) whatever the other inputs are, and the half-rate state is cleared.
- R6: Enable changes reach a bank only while its sources are low. No bank output ever produces a high pulse shorter than the selected clock's high phase.
- R7: The half-rate sequence restarts when `mr_n` is released. A half-rate bank first goes high at the second rising edge of the selected clock. A full-rate bank goes high at the first rising edge.
- R8: A change of `bank_full` made while the selected clock is high has no effect until that high phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First reference clock |
| clk_b | input | 1 | Second reference clock |
| ref_sel | input | 1 | Reference select, 1 picks clk_b |
| mr_n | input | 1 | Active-low master reset and global output disable |
| bank_en | input | 4 | Per-bank enable, 1 passes the clock |
| bank_full | input | 4 | Per-bank rate, 1 full rate, 0 half rate |
| q | output | 16 | Clock outputs, four per bank |
| q_oe | output | 4 | Per-bank output drive enable, 0 means high impedance |

## Verification
Suppose the half-rate register starts in the wrong phase after reset release. A half-rate bank would then rise on the first clock edge instead of the second, and the difference is visible within two input periods. A latch that is open at the wrong time shows up as a high pulse shorter than one input high phase. It can appear at any enable or rate change, so the enables are toggled at irregular offsets while every bank's pulse widths are measured. A stuck latch or a wrong source mux changes the period measured on an output within two output periods.

// File: rtl/clk_fanout_bank.sv
module clk_fanout_bank #(
  parameter int BANKS    = 4,
  parameter int PER_BANK = 4,
  localparam int OUTS    = BANKS * PER_BANK
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             ref_sel,
  input  logic             mr_n,
  input  logic [BANKS-1:0] bank_en,
  input  logic [BANKS-1:0] bank_full,
  output logic [OUTS-1:0]  q,
  output logic [BANKS-1:0] q_oe
);

  logic ref_clk;
  logic armed, half;
  logic gate_open;
  logic [BANKS-1:0] en_l, full_l, bank_q;

  assign ref_clk = ref_sel ? clk_b : clk_a;

  always_ff @(posedge ref_clk or negedge mr_n) begin
    if (!mr_n) begin
      armed <= 1'b0;
      half  <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (armed) half <= ~half;
    end
  end

  assign gate_open = ~ref_clk & ~half;

  always_latch begin
    if (gate_open) begin
      en_l   <= bank_en & {BANKS{mr_n}};
      full_l <= bank_full;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_q[b] = en_l[b] & (full_l[b] ? ref_clk : half);
    assign q[b*PER_BANK +: PER_BANK] = {PER_BANK{bank_q[b]}};
    assign q_oe[b] = mr_n;
  end

  logic seen_rise;
  logic [BANKS-1:0] en_rise, full_rise;

  always_ff @(posedge ref_clk or negedge mr_n) begin
    if (!mr_n) begin
      seen_rise <= 1'b0;
      en_rise   <= '0;
      full_rise <= '0;
    end else begin
      seen_rise <= 1'b1;
      en_rise   <= en_l;
      full_rise <= full_l;
    end
  end

  always @(posedge ref_clk) begin
    if (mr_n === 1'b0)
      a_r5_cleared: assert (!half && !armed);
  end

  a_r7_first_edge: assert property (@(posedge ref_clk) disable iff (!mr_n)
    !armed |=> !half);

  a_r3_toggle: assert property (@(posedge ref_clk) disable iff (!mr_n)
    armed |=> (half != $past(half)));

  a_r6_hold_high: assert property (@(negedge ref_clk) disable iff (!mr_n)
    seen_rise |-> (en_l == en_rise));

  a_r8_rate_hold: assert property (@(negedge ref_clk) disable iff (!mr_n)
    seen_rise |-> (full_l == full_rise));

endmodule

// File: tb/tb_clk_fanout_bank.sv
`timescale 1ns/1ps
module tb_clk_fanout_bank;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic ref_sel = 1'b0, mr_n = 1'b0;
  logic [3:0] bank_en = 4'hF, bank_full = 4'hF;
  logic [15:0] q;
  logic [3:0] q_oe;
  int checks = 0, failures = 0;
  bit mon = 1'b0;
  real min_w = 1.0e9;
  int pulses = 0;

  clk_fanout_bank dut (.clk_a(clk_a), .clk_b(clk_b), .ref_sel(ref_sel), .mr_n(mr_n),
    .bank_en(bank_en), .bank_full(bank_full), .q(q), .q_oe(q_oe));

  always #2 clk_a = ~clk_a;
  initial begin #0.7; forever #3 clk_b = ~clk_b; end

  for (genvar b = 0; b < 4; b++) begin : g_mon
    real t_up;
    always @(posedge q[4*b]) t_up = $realtime;
    always @(negedge q[4*b]) if (mon) begin
      pulses++;
      if ($realtime - t_up < min_w) min_w = $realtime - t_up;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic period_ps(input int idx, output int p);
    real t0;
    wait (q[idx] == 1'b0); wait (q[idx] == 1'b1);
    t0 = $realtime;
    wait (q[idx] == 1'b0); wait (q[idx] == 1'b1);
    p = int'(($realtime - t0) * 1000.0);
  endtask

  task automatic t_reset;
    bank_en = 4'h5; bank_full = 4'h3; mr_n = 1'b0;
    repeat (3) @(posedge clk_a);
    #1;
    check(q_oe == 4'h0, "R5 oe during reset", q_oe, 0);
    #2;
    check(q_oe == 4'h0, "R5 oe during reset low phase", q_oe, 0);
  endtask

  task automatic t_first_edge;
    bank_en = 4'hF; bank_full = 4'b0101;
    @(negedge clk_a); #0.5; mr_n = 1'b1;
    @(posedge clk_a); #0.5;
    check(q[0] == 1'b1, "R7 full bank at first rise", q[0], 1);
    check(q[4] == 1'b0, "R7 half bank at first rise", q[4], 0);
    @(posedge clk_a); #0.5;
    check(q[4] == 1'b1, "R7 half bank at second rise", q[4], 1);
    check(q_oe == 4'hF, "R5 oe after release", q_oe, 15);
  endtask

  task automatic t_rates;
    int p;
    period_ps(0, p);  check(p == 4000, "R2 full period bank A", p, 4000);
    period_ps(4, p);  check(p == 8000, "R3 half period bank B", p, 8000);
    period_ps(13, p); check(p == 8000, "R3 half period bank D", p, 8000);
    for (int k = 0; k < 12; k++) begin
      #0.9;
      for (int b = 0; b < 4; b++)
        check(q[4*b +: 4] == 4'h0 || q[4*b +: 4] == 4'hF, "R2 bank copies equal", q[4*b +: 4], {4{q[4*b]}});
    end
  endtask

  task automatic t_select;
    int p;
    ref_sel = 1'b1;
    repeat (4) @(posedge clk_b);
    period_ps(8, p); check(p == 6000, "R1 clk_b full period", p, 6000);
    period_ps(12, p); check(p == 12000, "R1 clk_b half period", p, 12000);
    ref_sel = 1'b0;
    repeat (4) @(posedge clk_a);
    period_ps(8, p); check(p == 4000, "R1 back to clk_a", p, 4000);
  endtask

  task automatic t_disable;
    int seen = 0;
    @(posedge clk_a); #1; bank_en[2] = 1'b0;
    repeat (4) @(posedge clk_a);
    for (int k = 0; k < 16; k++) begin
      #0.5;
      if (q[8 +: 4] != 4'h0) seen++;
    end
    check(seen == 0, "R4 disabled bank held low", seen, 0);
    check(q_oe[2] == 1'b1, "R4 oe stays high", q_oe[2], 1);
    bank_en[2] = 1'b1;
  endtask

  task automatic t_runt;
    min_w = 1.0e9; pulses = 0; mon = 1'b1;
    for (int i = 0; i < 60; i++) begin
      #(1.3 + (i % 5) * 0.7);
      bank_en = 4'(i * 7 + 3);
      if (i >= 30) bank_full = 4'(i * 5 + 1);
    end
    bank_en = 4'hF;
    repeat (4) @(posedge clk_a);
    mon = 1'b0;
    check(pulses > 10, "R6 pulses observed", pulses, 11);
    check(min_w >= 1.99, "R6 min high width ps", int'(min_w * 1000.0), 2000);
  endtask

  task automatic t_rate_change;
    int p;
    bank_full = 4'hF; bank_en = 4'hF;
    repeat (4) @(posedge clk_a);
    @(posedge clk_a); #1; bank_full[0] = 1'b0;
    #0.8;
    check(q[0] == 1'b1, "R8 rate change held in high phase", q[0], 1);
    repeat (2) @(posedge clk_a);
    period_ps(0, p); check(p == 8000, "R8 new rate applied", p, 8000);
  endtask

  task automatic t_reset_again;
    @(posedge clk_a); #1; mr_n = 1'b0; bank_en = 4'hF;
    #0.2;
    check(q_oe == 4'h0, "R5 oe drops with mr_n", q_oe, 0);
    #5;
    mr_n = 1'b1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_first_edge();
    t_rates();
    t_select();
    t_disable();
    t_runt();
    t_rate_change();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule